// File: doc/BRIEF.md
# Programmable Timer Channel with Clock, Edge and Clear Selection

This block is a single 16-bit up-counting timer channel. An 8-bit control register chooses where the count pulses come from (one of seven fixed divisions of the system clock, or an external pin), which transitions of the external pin advance the counter, and which event returns the counter to zero. Four general registers A, B, C and D are compared against the counter. A match on the selected register clears the counter on the next clock edge.

Channels can be tied together. Each channel drives a synchronous-clear output when its own selected A–D match clears it. It also accepts a synchronous-clear input from a neighbour, which only has an effect when the synchronous-operation enable input is high. Registers C and D can be flagged as buffers. A buffered register never produces a match, so choosing it as the clear source never clears the counter.

Top module: `tmr_chan`

## Requirements
- R1: The control register resets to 0x00. A write stores all 8 bits and they read back unchanged. Field layout: bits [7:5] select the clear source, bits [4:3] select the pin edge, bits [2:0] select the count source.
- R2: The count-source codes give these system-clock divisions: 000 →1, 001 →4, 010 →16, 011 →64, 101 →1024, 110 →256, 111 →4096. The divider is free-running, so over any window of 8192 cycles the counter advances by exactly 8192 divided by the ratio.
- R3: Count-source code 100 counts transitions of the external pin only. The pin passes through a two-flop synchroniser, and each selected transition adds exactly one count.
- R4: With an external source, edge code 00 counts rising transitions, 01 counts falling transitions, and 10 or 11 counts both.
- R5: Clear codes 001, 010, 101 and 110 clear the counter on a match of register A, B, C and D respectively. The counter reads 0 on the cycle after the cycle in which it equals that register.
- R6: Clear codes 000 and 100 never clear the counter. The counter wraps from 0xFFFF to 0x0000.
- R7: Clear codes 011 and 111 clear the counter on the cycle after the synchronous-clear input is high, but only while the synchronous-operation enable is 1. When the enable is 0, that input has no effect.
- R8: When buffer mode is set for C (or D), clear code 101 (or 110) never clears the counter and never raises the synchronous-clear output.
- R9: When a clear and a count pulse fall in the same cycle, the clear wins.
- R10: The synchronous-clear output is high in exactly the cycles in which the selected A–D register matches the counter. It stays low for a clear caused by the synchronous-clear input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_q | output | 8 | Control register read value |
| ext_clk_pin | input | 1 | External count pin (asynchronous) |
| sync_en | input | 1 | Synchronous-operation enable |
| sync_clr_in | input | 1 | Synchronous clear from another channel |
| buf_c_en | input | 1 | Register C in buffer mode |
| buf_d_en | input | 1 | Register D in buffer mode |
| gr_a | input | 16 | General register A |
| gr_b | input | 16 | General register B |
| gr_c | input | 16 | General register C |
| gr_d | input | 16 | General register D |
| count_q | output | 16 | Counter value |
| sync_clr_out | output | 1 | Synchronous clear to other channels |

## Verification
A clear and a count pulse can fall in the same cycle. This is the normal case with divide-by-1: a register match, or a synchronous-clear input pulse, arrives while the count enable is high every cycle. The bench runs each clear code this way and predicts that the counter reads 0 on the following cycle, not the incremented value. It checks the counter value cycle by cycle through a full clear period. For the synchronous-clear input, it checks the value just before the pulse, the zero after it, and the restart from zero.

// File: rtl/tmr_pkg.sv
// Package: shared control-register layout and code values for the timer channel.
package tmr_pkg;

    // Control register fields, most significant first.
    typedef struct packed {
        logic [2:0] clr_sel;
        logic [1:0] edge_sel;
        logic [2:0] psc_sel;
    } tmr_ctl_t;

    localparam logic [2:0] PSC_EXT = 3'b100;

    // Returns log2 of the division ratio for an internal source code.
    function automatic int unsigned psc_shift(input int unsigned code);
        case (code)
            0:       return 0;
            1:       return 2;
            2:       return 4;
            3:       return 6;
            5:       return 10;
            6:       return 8;
            7:       return 12;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
// Module: free-running divider giving one count-enable pulse per division period.
// Assumes DIV_W is at least the largest shift (12). The external code yields no pulse.
module tmr_prescale #(
    parameter int DIV_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] psc_sel,
    output logic       tick_o
);
    import tmr_pkg::*;

    localparam int NUM_CODES = 8;

    logic [DIV_W-1:0]     div_q;
    logic [NUM_CODES-1:0] tap;

    // Advance the shared divider every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // One tap per source code: high when the low bits of the divider are all ones.
    for (genvar c = 0; c < NUM_CODES; c++) begin : g_tap
        localparam int unsigned SH = psc_shift(c);
        if (c == int'(PSC_EXT)) begin : g_ext
            assign tap[c] = 1'b0;
        end else if (SH == 0) begin : g_div1
            assign tap[c] = 1'b1;
        end else begin : g_divn
            assign tap[c] = &div_q[SH-1:0];
        end
    end

    // Pick the tap for the selected code.
    assign tick_o = tap[psc_sel];

    // The divide-by-4 tap never fires in two adjacent cycles.
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tap[1] |=> !tap[1]);

endmodule

// File: rtl/tmr_edge.sv
// Module: synchronises the external pin and turns the selected transitions into pulses.
// Assumes the pin is asynchronous. Each output pulse lasts exactly one cycle.
module tmr_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [1:0] edge_sel,
    output logic       pulse_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   pin_s;
    logic                   rise;
    logic                   fall;

    // Shift the pin through the synchroniser and keep the last synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign pin_s = sync_q[SYNC_STAGES-1];
    assign rise  = pin_s & ~prev_q;
    assign fall  = ~pin_s & prev_q;

    // Choose which transitions count.
    always_comb begin
        case (edge_sel)
            2'b00:   pulse_o = rise;
            2'b01:   pulse_o = fall;
            default: pulse_o = rise | fall;
        endcase
    end

    p_rise_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    p_fall_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/tmr_clear.sv
// Module: compare-match and clear-source selection.
// A buffered C or D register produces no match. Synchronous clear needs sync_en.
module tmr_clear #(
    parameter int CNT_W = 16,
    parameter int NUM_GR = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CNT_W-1:0]             count_i,
    input  logic [NUM_GR-1:0][CNT_W-1:0] gr_i,
    input  logic [NUM_GR-1:0]            buf_i,
    input  logic [2:0]                   clr_sel,
    input  logic                         sync_en,
    input  logic                         sync_in,
    output logic                         clr_o,
    output logic                         sync_out_o
);
    logic [NUM_GR-1:0] hit;
    logic              own_clr;
    logic              sync_hit;

    // Raw match per register, masked while the register is a buffer.
    for (genvar g = 0; g < NUM_GR; g++) begin : g_hit
        assign hit[g] = (count_i == gr_i[g]) & ~buf_i[g];
    end

    // Map the clear code onto a register match.
    always_comb begin
        case (clr_sel)
            3'b001:  own_clr = hit[0];
            3'b010:  own_clr = hit[1];
            3'b101:  own_clr = hit[2];
            3'b110:  own_clr = hit[3];
            default: own_clr = 1'b0;
        endcase
    end

    assign sync_hit   = (clr_sel[1:0] == 2'b11) & sync_en & sync_in;
    assign clr_o      = own_clr | sync_hit;
    assign sync_out_o = own_clr;

    p_buf_c_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_i[2] && clr_sel == 3'b101) |-> !clr_o && !sync_out_o);
    p_buf_d_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_i[3] && clr_sel == 3'b110) |-> !clr_o && !sync_out_o);
    p_sync_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sel[1:0] == 2'b11 && !sync_en) |-> !clr_o);

endmodule

// File: rtl/tmr_counter.sv
// Module: the up-counter itself. Clear beats increment and the counter wraps at the top.
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] count_o
);
    // Clear has priority, then count.
    always_ff @(posedge clk) begin
        if (!rst_n)     count_o <= '0;
        else if (clr_i) count_o <= '0;
        else if (en_i)  count_o <= count_o + 1'b1;
    end

    p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> count_o == '0);
    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i) |=> count_o == $past(count_o) + 1'b1);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> $stable(count_o));

endmodule

// File: rtl/tmr_chan.sv
// Module: top of one timer channel. Holds the control register and wires the
// prescaler, pin edge detector, clear selection and counter together.
module tmr_chan #(
    parameter int CNT_W = 16,
    parameter int DIV_W = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [7:0]       ctl_wdata,
    output logic [7:0]       ctl_q,
    input  logic             ext_clk_pin,
    input  logic             sync_en,
    input  logic             sync_clr_in,
    input  logic             buf_c_en,
    input  logic             buf_d_en,
    input  logic [CNT_W-1:0] gr_a,
    input  logic [CNT_W-1:0] gr_b,
    input  logic [CNT_W-1:0] gr_c,
    input  logic [CNT_W-1:0] gr_d,
    output logic [CNT_W-1:0] count_q,
    output logic             sync_clr_out
);
    import tmr_pkg::*;

    localparam int NUM_GR = 4;

    tmr_ctl_t                    ctl;
    logic                        int_tick;
    logic                        ext_pulse;
    logic                        cnt_en;
    logic                        clr;
    logic [NUM_GR-1:0][CNT_W-1:0] gr_bus;
    logic [NUM_GR-1:0]           buf_bus;

    // Control register: load on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl <= '0;
        else if (ctl_wr) ctl <= tmr_ctl_t'(ctl_wdata);
    end

    assign ctl_q   = ctl;
    assign gr_bus  = {gr_d, gr_c, gr_b, gr_a};
    assign buf_bus = {buf_d_en, buf_c_en, 2'b00};
    assign cnt_en  = (ctl.psc_sel == PSC_EXT) ? ext_pulse : int_tick;

    tmr_prescale #(.DIV_W(DIV_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .psc_sel (ctl.psc_sel),
        .tick_o  (int_tick)
    );

    tmr_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (ext_clk_pin),
        .edge_sel (ctl.edge_sel),
        .pulse_o  (ext_pulse)
    );

    tmr_clear #(.CNT_W(CNT_W), .NUM_GR(NUM_GR)) u_clr (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_i    (count_q),
        .gr_i       (gr_bus),
        .buf_i      (buf_bus),
        .clr_sel    (ctl.clr_sel),
        .sync_en    (sync_en),
        .sync_in    (sync_clr_in),
        .clr_o      (clr),
        .sync_out_o (sync_clr_out)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (cnt_en),
        .clr_i   (clr),
        .count_o (count_q)
    );

    p_ext_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.psc_sel == PSC_EXT && !ext_pulse && !clr) |=> $stable(count_q));
    p_sync_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr_out |=> count_q == '0);

endmodule

// File: tb/tmr_chan_tb_top.sv
// Scoreboard bench: driver tasks queue expected values stamped with a cycle number,
// and a negedge monitor pops and compares them against the outputs.
module tmr_chan_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    typedef struct {
        int    at;
        int    sel;   // 0 count, 1 control readback, 2 sync-clear output
        int    exp;
        string req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic [7:0]  ctl_q;
    logic        ext_clk_pin = 1'b0;
    logic        sync_en = 1'b0;
    logic        sync_clr_in = 1'b0;
    logic        buf_c_en = 1'b0;
    logic        buf_d_en = 1'b0;
    logic [15:0] gr_a = 16'd20;
    logic [15:0] gr_b = 16'd21;
    logic [15:0] gr_c = 16'd22;
    logic [15:0] gr_d = 16'd23;
    logic [15:0] count_q;
    logic        sync_clr_out;

    int    cyc = 0;
    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    item_t q[$];

    tmr_chan dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
        .ext_clk_pin(ext_clk_pin), .sync_en(sync_en), .sync_clr_in(sync_clr_in),
        .buf_c_en(buf_c_en), .buf_d_en(buf_d_en), .gr_a(gr_a), .gr_b(gr_b),
        .gr_c(gr_c), .gr_d(gr_d), .count_q(count_q), .sync_clr_out(sync_clr_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(input int at, input int sel, input int exp, input string req);
        item_t it;
        it.at = at; it.sel = sel; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    // Monitor: compare every item due in this cycle.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            item_t it;
            int    act;
            it = q.pop_front();
            act = (it.sel == 0) ? int'(count_q) : (it.sel == 1) ? int'(ctl_q) : int'(sync_clr_out);
            total++;
            if (it.at != cyc || act != it.exp) begin
                bad++;
                $display("FAIL %s: cyc=%0d sel=%0d actual=%0d expected=%0d",
                         it.req, cyc, it.sel, act, it.exp);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic write_ctl(input logic [7:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R2: the counter advances by 8192/ratio over a window of 8192 cycles.
    task automatic check_psc(input logic [2:0] code, input int shift);
        int v;
        write_ctl({3'b000, 2'b00, code});
        v = count_q;
        expect_at(cyc + 8192, 0, (v + (8192 >> shift)) & 16'hFFFF, "R2 prescale ratio");
        wait_cyc(8192);
    endtask

    // R3/R4: n pulses on the pin, each level held 4 cycles, then settle.
    task automatic check_edge(input logic [1:0] ec, input int n, input int per);
        int v;
        write_ctl({3'b000, ec, 3'b100});
        v = count_q;
        expect_at(cyc + n * 8 + 6, 0, (v + n * per) & 16'hFFFF, "R3 R4 pin edge count");
        for (int i = 0; i < n; i++) begin
            ext_clk_pin = 1'b1; wait_cyc(4);
            ext_clk_pin = 1'b0; wait_cyc(4);
        end
        wait_cyc(6);
    endtask

    // R5/R9/R10: clear on a register match at divide-by-1.
    task automatic check_match(input logic [2:0] cc, input int g, input string req);
        int v;
        do_reset();
        write_ctl({cc, 2'b00, 3'b000});
        v = count_q;
        for (int k = 1; k <= 2 * (g + 1) + 3; k++) begin
            int e;
            e = (v + k) % (g + 1);
            expect_at(cyc + k, 0, e, req);
            expect_at(cyc + k, 2, (e == g) ? 1 : 0, "R10 sync out on match");
        end
        wait_cyc(2 * (g + 1) + 4);
    endtask

    // R6/R8: no clear; the counter runs straight past the register value.
    task automatic check_noclear(input logic [2:0] cc, input int g, input string req);
        int v;
        do_reset();
        write_ctl({cc, 2'b00, 3'b000});
        v = count_q;
        for (int k = 1; k <= g + 5; k++) begin
            expect_at(cyc + k, 0, v + k, req);
            expect_at(cyc + k, 2, 0, req);
        end
        wait_cyc(g + 6);
    endtask

    // R7/R9: a synchronous-clear pulse at divide-by-1, with or without the enable.
    task automatic check_sync(input logic [2:0] cc, input logic en);
        int v;
        int c0;
        do_reset();
        sync_en = en;
        write_ctl({cc, 2'b00, 3'b000});
        v = count_q;
        c0 = cyc;
        expect_at(c0 + 5, 0, v + 5, "R7 before sync pulse");
        expect_at(c0 + 6, 0, en ? 0 : v + 6, "R7 R9 sync clear beats count");
        expect_at(c0 + 6, 2, 0, "R10 no sync out from sync clear");
        expect_at(c0 + 7, 0, en ? 1 : v + 7, "R7 restart after sync");
        wait_cyc(5);
        sync_clr_in = 1'b1;
        wait_cyc(1);
        sync_clr_in = 1'b0;
        wait_cyc(3);
        sync_en = 1'b0;
    endtask

    initial begin : driver
        int v;
        do_reset();
        // R1: reset value and readback.
        expect_at(cyc, 1, 0, "R1 control reset value");
        expect_at(cyc, 0, 0, "R1 counter reset value");
        wait_cyc(1);
        write_ctl(8'hA5);
        expect_at(cyc, 1, 8'hA5, "R1 readback A5");
        wait_cyc(1);
        write_ctl(8'h5A);
        expect_at(cyc, 1, 8'h5A, "R1 readback 5A");
        wait_cyc(1);

        // R2: every internal count source.
        gr_a = 16'hFFFF; gr_b = 16'hFFFF; gr_c = 16'hFFFF; gr_d = 16'hFFFF;
        check_psc(3'b000, 0);
        check_psc(3'b001, 2);
        check_psc(3'b010, 4);
        check_psc(3'b011, 6);
        check_psc(3'b101, 10);
        check_psc(3'b110, 8);
        check_psc(3'b111, 12);

        // R3, R4: external pin with each edge code.
        check_edge(2'b00, 5, 1);
        check_edge(2'b01, 5, 1);
        check_edge(2'b10, 5, 2);
        check_edge(2'b11, 3, 2);

        // R5, R9, R10: each register clear code.
        gr_a = 16'd20; gr_b = 16'd21; gr_c = 16'd22; gr_d = 16'd23;
        check_match(3'b001, 20, "R5 clear on A");
        check_match(3'b010, 21, "R5 clear on B");
        check_match(3'b101, 22, "R5 clear on C");
        check_match(3'b110, 23, "R5 clear on D");

        // R8: buffered C and D never clear.
        buf_c_en = 1'b1;
        check_noclear(3'b101, 22, "R8 buffered C no clear");
        buf_c_en = 1'b0; buf_d_en = 1'b1;
        check_noclear(3'b110, 23, "R8 buffered D no clear");
        buf_d_en = 1'b0;

        // R6: disabled clear codes, then the wrap.
        check_noclear(3'b100, 20, "R6 code 100 no clear");
        check_noclear(3'b000, 20, "R6 code 000 no clear");
        v = count_q;
        expect_at(cyc + (65536 - v), 0, 0, "R6 wrap to zero");
        expect_at(cyc + (65536 - v) + 1, 0, 1, "R6 count after wrap");
        wait_cyc(65536 - v + 2);

        // R7: synchronous clear codes, with and without enable.
        check_sync(3'b011, 1'b1);
        check_sync(3'b111, 1'b1);
        check_sync(3'b011, 1'b0);
        check_sync(3'b111, 1'b0);

        wait_cyc(2);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : watchdog
        wait (cyc >= WATCHDOG);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cyc, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule